// File: doc/BRIEF.md
# Interrupt Recognition Controller

This block sits beside the instruction sequencer of a small 8-bit processor model. Once per instruction it decides whether to begin an interrupt response. It has four request sources:

- an active-low maskable request, which is level-sensitive and is not stored;
- an active-low non-maskable request, which is edge-triggered and held by an internal pending latch;
- an active-low bus request;
- two sequencer status lines: "last T-state" and "prefix in progress".

The block samples requests only at a true instruction boundary. That is the clock edge where the last-T-state flag is high and no prefix is open. A fixed priority is applied at that point: bus request first, then non-maskable, then maskable. The result is either a bus grant or a one-clock start pulse. For a maskable request, the block also plays out a mock acknowledge cycle on its M1 and IORQ outputs. An interrupt-enable flag is set by an EI strobe and cleared by a DI strobe. After EI, the flag takes effect one instruction late.

Top module: `irq_recog_ctrl`

## Requirements
- R1: While reset is active, start_nmi, start_int and bus_grant are 0, m1_n and iorq_n are 1, and the interrupt-enable flag is clear.
- R2: The maskable request is only examined on a clock edge where last_t is 1. A low int_n in any other cycle starts nothing.
- R3: The maskable request is not stored. A low pulse on int_n that has ended before the boundary edge starts nothing.
- R4: At a boundary the priority is fixed: bus request over non-maskable, and non-maskable over maskable. Only the winner is acted on.
- R5: A falling edge on nmi_n at any time sets a pending latch. The latch is serviced at the next boundary whatever the enable flag holds. A level that stays low produces no second service.
- R6: When last_t coincides with prefix_act = 1, no interrupt and no grant is started.
- R7: A maskable request is ignored while the enable flag is clear. A DI strobe clears the flag.
- R8: Accepting any interrupt clears the enable flag. Accepting a non-maskable request clears its pending latch.
- R9: After an EI strobe, the boundary that ends the EI instruction does not accept a maskable request. The boundary after it does.
- R10: An accepted maskable request produces an acknowledge cycle of ACK_LEN clocks (default 4). m1_n is 0 for every clock of the cycle, and iorq_n is 0 for its final two clocks. A non-maskable acceptance drives neither line.
- R11: A bus request seen at a boundary raises bus_grant. bus_grant stays high until busreq_n returns high, and no interrupt is started meanwhile. A pending non-maskable request survives the grant.
- R12: Each acceptance pulses exactly one of start_nmi or start_int, for one clock, in the clock after the boundary edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| int_n | input | 1 | Maskable request, active low, level-sensitive |
| nmi_n | input | 1 | Non-maskable request, active low, taken on its falling edge |
| busreq_n | input | 1 | Bus request, active low |
| last_t | input | 1 | Sequencer: the current clock is the last T-state of the instruction |
| prefix_act | input | 1 | Sequencer: a prefix has been fetched and its opcode has not |
| ei_stb | input | 1 | One-clock strobe from an EI instruction |
| di_stb | input | 1 | One-clock strobe from a DI instruction |
| start_nmi | output | 1 | One-clock pulse: non-maskable response begins |
| start_int | output | 1 | One-clock pulse: maskable response begins |
| bus_grant | output | 1 | Bus released to the requester |
| m1_n | output | 1 | Active-low M1 of the acknowledge cycle |
| iorq_n | output | 1 | Active-low IORQ of the acknowledge cycle |

## Verification
The assertions take the sequencer status as well-formed: EI and DI strobes never fall in the same clock, and last_t is a single-clock pulse per instruction. They also take a prefix as never spanning an acknowledge cycle or a bus grant. The bench drives every sequencer input on the falling clock edge and never raises last_t during an acknowledge cycle or a grant. It keeps nmi_n pulses at least one clock wide, and waits enough clocks after each pulse for the input synchroniser to pass the edge before it applies a boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    RESP_NONE,
    RESP_GRANT,
    RESP_NMI,
    RESP_INT
  } resp_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ACK,
    ST_HOLD
  } seq_e;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clr,
  output logic pend
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic fall;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], nmi_n};
    prev_d = sync_q[SYNC_STAGES-1];
    fall   = prev_q & ~sync_q[SYNC_STAGES-1];
    if (fall)
      pend_d = 1'b1;
    else if (clr)
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R5
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/irq_ie_flag.sv
module irq_ie_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ei,
  input  logic di,
  input  logic boundary,
  input  logic clr,
  output logic ie,
  output logic ok
);

  logic ie_q, ie_d;
  logic shadow_q, shadow_d;

  always_comb begin
    if (clr)
      ie_d = 1'b0;
    else if (di)
      ie_d = 1'b0;
    else if (ei)
      ie_d = 1'b1;
    else
      ie_d = ie_q;

    if (ei)
      shadow_d = 1'b1;
    else if (boundary)
      shadow_d = 1'b0;
    else
      shadow_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      ie_q     <= ie_d;
      shadow_q <= shadow_d;
    end
  end

  assign ie = ie_q;
  assign ok = ie_q & ~shadow_q;

  // R9
  ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ei |=> !ok);

  // R7
  di_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (di && !ei) |=> !ie_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic  sample,
  input  logic  busreq,
  input  logic  nmi_pend,
  input  logic  int_req,
  input  logic  int_ok,
  output resp_e resp
);

  always_comb begin
    resp = RESP_NONE;
    if (sample) begin
      if (busreq)
        resp = RESP_GRANT;
      else if (nmi_pend)
        resp = RESP_NMI;
      else if (int_req && int_ok)
        resp = RESP_INT;
    end
  end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_pkg::*;
#(
  parameter int ACK_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  resp_e resp,
  input  logic  busreq,
  output logic  start_nmi,
  output logic  start_int,
  output logic  grant,
  output logic  idle,
  output logic  m1_n,
  output logic  iorq_n
);

  localparam int CW = (ACK_LEN > 2) ? $clog2(ACK_LEN) : 2;
  localparam logic [CW-1:0] CNT_LAST  = CW'(ACK_LEN - 1);
  localparam logic [CW-1:0] IORQ_FROM = CW'(ACK_LEN - 2);

  seq_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic snmi_q, snmi_d;
  logic sint_q, sint_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    snmi_d  = 1'b0;
    sint_d  = 1'b0;
    case (state_q)
      ST_RUN: begin
        case (resp)
          RESP_GRANT: state_d = ST_HOLD;
          RESP_NMI:   snmi_d = 1'b1;
          RESP_INT: begin
            state_d = ST_ACK;
            cnt_d   = '0;
            sint_d  = 1'b1;
          end
          default: ;
        endcase
      end
      ST_ACK: begin
        if (cnt_q == CNT_LAST)
          state_d = ST_RUN;
        else
          cnt_d = cnt_q + 1'b1;
      end
      ST_HOLD: begin
        if (!busreq)
          state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      snmi_q  <= 1'b0;
      sint_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      snmi_q  <= snmi_d;
      sint_q  <= sint_d;
    end
  end

  assign start_nmi = snmi_q;
  assign start_int = sint_q;
  assign grant     = (state_q == ST_HOLD);
  assign idle      = (state_q == ST_RUN);
  assign m1_n      = ~(state_q == ST_ACK);
  assign iorq_n    = ~((state_q == ST_ACK) && (cnt_q >= IORQ_FROM));

  // R10
  iorq_in_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n |-> !m1_n);

  // R10
  ack_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_int |-> (!m1_n && iorq_n));

  // R12
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_nmi, start_int}));

  // R12
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_int || start_nmi) |=> !(start_int || start_nmi));

endmodule

// File: rtl/irq_recog_ctrl.sv
module irq_recog_ctrl
  import irq_pkg::*;
#(
  parameter int ACK_LEN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_n,
  input  logic nmi_n,
  input  logic busreq_n,
  input  logic last_t,
  input  logic prefix_act,
  input  logic ei_stb,
  input  logic di_stb,
  output logic start_nmi,
  output logic start_int,
  output logic bus_grant,
  output logic m1_n,
  output logic iorq_n
);

  logic [1:0] rs_q;
  logic rst_i;
  logic boundary, sample, idle;
  logic nmi_pend, ie, int_ok;
  resp_e resp;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= 2'b00;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign boundary = last_t & ~prefix_act;
  assign sample   = boundary & idle;

  irq_nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk   (clk),
    .rst_n (rst_i),
    .nmi_n (nmi_n),
    .clr   (resp == RESP_NMI),
    .pend  (nmi_pend)
  );

  irq_ie_flag u_ie (
    .clk      (clk),
    .rst_n    (rst_i),
    .ei       (ei_stb),
    .di       (di_stb),
    .boundary (boundary),
    .clr      ((resp == RESP_NMI) || (resp == RESP_INT)),
    .ie       (ie),
    .ok       (int_ok)
  );

  irq_arbiter u_arb (
    .sample   (sample),
    .busreq   (~busreq_n),
    .nmi_pend (nmi_pend),
    .int_req  (~int_n),
    .int_ok   (int_ok),
    .resp     (resp)
  );

  irq_ack_seq #(.ACK_LEN(ACK_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i),
    .resp      (resp),
    .busreq    (~busreq_n),
    .start_nmi (start_nmi),
    .start_int (start_int),
    .grant     (bus_grant),
    .idle      (idle),
    .m1_n      (m1_n),
    .iorq_n    (iorq_n)
  );

  // R8
  accept_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (start_int || start_nmi) |-> !ie);

  // R11
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_grant && !busreq_n) |=> bus_grant);

  // R6
  prefix_block_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (last_t && prefix_act && idle) |=> !(start_int || start_nmi || bus_grant));

endmodule

// File: tb/sim_irq_recog_ctrl.sv
module sim_irq_recog_ctrl;

  logic clk = 1'b0;
  logic rst_n, int_n, nmi_n, busreq_n, last_t, prefix_act, ei_stb, di_stb;
  logic start_nmi, start_int, bus_grant, m1_n, iorq_n;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_recog_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n),
    .busreq_n(busreq_n), .last_t(last_t), .prefix_act(prefix_act),
    .ei_stb(ei_stb), .di_stb(di_stb), .start_nmi(start_nmi),
    .start_int(start_int), .bus_grant(bus_grant), .m1_n(m1_n),
    .iorq_n(iorq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // one instruction boundary; returns at the falling edge after the decision edge
  task automatic bnd(input logic pfx);
    last_t = 1'b1;
    prefix_act = pfx;
    tick();
    last_t = 1'b0;
    prefix_act = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi_n = 1'b0;
    tick();
    nmi_n = 1'b1;
    tick(4);
  endtask

  // EI strobe followed by the end of the EI instruction
  task automatic ei_seq();
    ei_stb = 1'b1;
    tick();
    ei_stb = 1'b0;
    tick();
    bnd(1'b0);
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(2);
    chk("R1 start_nmi", start_nmi, 0);
    chk("R1 start_int", start_int, 0);
    chk("R1 bus_grant", bus_grant, 0);
    chk("R1 m1_n", m1_n, 1);
    chk("R1 iorq_n", iorq_n, 1);
    rst_n = 1'b1;
    tick(3);
    int_n = 1'b0;
    bnd(1'b0);
    chk("R1 ie clear after reset", start_int, 0);
    int_n = 1'b1;
    tick();
  endtask

  task automatic t_ack_cycle();
    int_n = 1'b0;
    ei_stb = 1'b1;
    tick();
    ei_stb = 1'b0;
    tick();
    bnd(1'b0);
    chk("R9 no accept at end of EI", start_int, 0);
    tick(3);
    chk("R2 no accept off boundary", start_int, 0);
    chk("R2 m1 idle off boundary", m1_n, 1);
    bnd(1'b0);
    int_n = 1'b1;
    chk("R12 start_int pulse", start_int, 1);
    chk("R12 no start_nmi", start_nmi, 0);
    chk("R10 m1 clk1", m1_n, 0);
    chk("R10 iorq clk1", iorq_n, 1);
    tick();
    chk("R12 pulse one clock", start_int, 0);
    chk("R10 m1 clk2", m1_n, 0);
    chk("R10 iorq clk2", iorq_n, 1);
    tick();
    chk("R10 m1 clk3", m1_n, 0);
    chk("R10 iorq clk3", iorq_n, 0);
    tick();
    chk("R10 m1 clk4", m1_n, 0);
    chk("R10 iorq clk4", iorq_n, 0);
    tick();
    chk("R10 m1 end", m1_n, 1);
    chk("R10 iorq end", iorq_n, 1);
    int_n = 1'b0;
    bnd(1'b0);
    chk("R8 ie cleared by accept", start_int, 0);
    int_n = 1'b1;
    tick();
  endtask

  task automatic t_not_latched();
    ei_seq();
    int_n = 1'b0;
    tick(2);
    int_n = 1'b1;
    tick();
    bnd(1'b0);
    chk("R3 ended pulse ignored", start_int, 0);
    chk("R3 m1 stays high", m1_n, 1);
    tick();
  endtask

  task automatic t_disabled();
    di_stb = 1'b1;
    tick();
    di_stb = 1'b0;
    int_n = 1'b0;
    tick();
    bnd(1'b0);
    chk("R7 request ignored after DI", start_int, 0);
    int_n = 1'b1;
    tick();
  endtask

  task automatic t_prefix();
    ei_seq();
    int_n = 1'b0;
    bnd(1'b1);
    chk("R6 no accept after prefix", start_int, 0);
    tick();
    bnd(1'b0);
    chk("R6 accepted at real boundary", start_int, 1);
    int_n = 1'b1;
    tick(5);
  endtask

  task automatic t_nmi();
    nmi_pulse();
    bnd(1'b0);
    chk("R5 nmi serviced with ie clear", start_nmi, 1);
    chk("R10 no m1 for nmi", m1_n, 1);
    tick();
    bnd(1'b0);
    chk("R8 nmi pending cleared", start_nmi, 0);
    nmi_n = 1'b0;
    tick(4);
    bnd(1'b0);
    chk("R5 held low first service", start_nmi, 1);
    tick(2);
    bnd(1'b0);
    chk("R5 held low no repeat", start_nmi, 0);
    nmi_n = 1'b1;
    tick(2);
  endtask

  task automatic t_priority();
    ei_seq();
    int_n = 1'b0;
    nmi_pulse();
    bnd(1'b0);
    chk("R4 nmi beats int: nmi", start_nmi, 1);
    chk("R4 nmi beats int: int", start_int, 0);
    tick();
    bnd(1'b0);
    chk("R8 ie cleared by nmi accept", start_int, 0);
    int_n = 1'b1;
    nmi_pulse();
    busreq_n = 1'b0;
    bnd(1'b0);
    chk("R4 bus request wins: grant", bus_grant, 1);
    chk("R4 bus request wins: nmi", start_nmi, 0);
    tick(3);
    chk("R11 grant held", bus_grant, 1);
    chk("R11 no start during grant", start_nmi, 0);
    busreq_n = 1'b1;
    tick();
    chk("R11 grant released", bus_grant, 0);
    bnd(1'b0);
    chk("R11 nmi kept across grant", start_nmi, 1);
    tick();
  endtask

  initial begin
    rst_n = 1'b0; int_n = 1'b1; nmi_n = 1'b1; busreq_n = 1'b1;
    last_t = 1'b0; prefix_act = 1'b0; ei_stb = 1'b0; di_stb = 1'b0;
    @(negedge clk);
    t_reset();
    t_ack_cycle();
    t_not_latched();
    t_disabled();
    t_prefix();
    t_nmi();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule